// File: doc/BRIEF.md
# SECDED and Address-Parity Guarded RAM

This block wraps a single-port behavioural RAM shared by one functional requester and a background scrubber. Every word is stored with a single-error-correct, double-error-detect code. The protected field holds the data plus one parity bit taken over the access address. A fault in the row decoder makes a read return a word that was written for another row. That fault shows up as an address-parity mismatch, so it is not returned silently as good data.

Reads take one cycle. The decoder always corrects a single flipped bit before the data leaves the block. Two sticky flags report what was seen: a corrected single error and an uncorrectable error. The uncorrectable flag covers both a double-bit error and an address mismatch. The flags sit behind a two-address register port, and each flag is cleared by writing a one to its bit.

The block has two level interrupt outputs, a non-fatal one and a fatal one. An escalation bit moves corrected single errors from the non-fatal output to the fatal one. Uncorrectable errors always drive the fatal output. When software sets the scrub enable, the scrubber uses idle cycles to walk the array and write back any word that holds a correctable error.

Top module: `guarded_ram`

## Requirements
- R1: Each write stores a codeword built as follows, and a later read recovers the data and the stored address parity from it.
  - The protected field is the DW data bits, with the XOR of all address bits placed above them as field bit DW.
  - The field is placed at the Hamming positions that are not powers of two, in ascending order.
  - The check bits sit at the power-of-two positions.
  - Bit 0 holds the even parity of the whole word.
  - With the default DW=16 the word is 23 bits wide, and the address-parity bit sits at bit 22.
- R2: A functional read request sampled at one clock edge raises `rdValid` for exactly the next cycle, with `rdata` valid in that cycle. Any single flipped stored bit is corrected in `rdata`, whether or not escalation is on.
- R3: A read that finds two flipped bits sets the uncorrectable flag, which is status bit 1. The flag is visible from the cycle after `rdValid`.
- R4: A read that returns a word whose stored address parity differs from the parity of the requested address sets the uncorrectable flag and drives `errIrq`. An example is a word copied from a row of opposite parity.
- R5: A flipped address-parity bit (bit 22) is corrected like any data bit. It sets only the corrected flag (status bit 0) and never the uncorrectable flag.
- R6: A read that finds one flipped bit sets the corrected flag. Both flags stay set until software clears them.
- R7: Status is read at `csrAddr`=1, with bit 0 for corrected and bit 1 for uncorrectable.
  - Writing there with a data bit at 1 clears that flag.
  - If a new event arrives in the same cycle as the clear, the flag stays set.
- R8: The escalation bit is bit 0 at `csrAddr`=0 and resets to 0. It controls where the corrected flag is routed:
  - While the bit is 0, `faultIrq` equals the corrected flag.
  - While the bit is 1, the corrected flag drives `errIrq` and `faultIrq` stays low.
  - The uncorrectable flag always drives `errIrq`.
- R9: A functional request is served in the cycle it is presented. The scrubber touches the array only in cycles with `req` low, so it makes no progress while requests come back to back.
- R10: With `scrubEn` high and idle cycles available, the scrubber reads every address in turn. Its reads set the flags like functional reads do. When it finds a corrected error it writes the repaired word back, so a later functional read of that word reports no error.
- R11: After reset both flags and the escalation bit are 0, and `rdValid`, `faultIrq` and `errIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Functional access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Corrected read data |
| rdValid | output | 1 | Read data valid, one cycle after a read request |
| scrubEn | input | 1 | Enables the background scrubber |
| csrWrite | input | 1 | Register write strobe |
| csrAddr | input | 1 | 0 = control, 1 = status |
| csrWdata | input | 2 | Register write data |
| csrRdata | output | 2 | Register read data |
| faultIrq | output | 1 | Non-fatal interrupt, level |
| errIrq | output | 1 | Fatal interrupt, level |

## Verification
A wrong decode shows at the ports in the `rdValid` cycle, as `rdata` that differs from the last value written. A wrong flag update appears on `faultIrq` or `errIrq` one cycle later. Because both interrupts are compared on every clock against a model of the flags, a flag that is set, cleared or routed wrongly is caught on the clock edge after the mistake. A scrubber fault only becomes visible later, when a functional read of the scrubbed word still reports an error, or when the corrected flag fails to rise during an idle scrub pass.

// File: rtl/guarded_ram_pkg.sv
package guarded_ram_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic memWrite;
    logic memRead;
    logic useFixed;   // write back the corrected word instead of wdata
  } memStrobe_t;

  // Smallest number of Hamming check bits for k protected bits.
  function automatic int checkBits(int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

endpackage

// File: rtl/guarded_ram_dp.sv
module guarded_ram_dp
  import guarded_ram_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  memStrobe_t    strobe,
  input  logic [AW-1:0] memAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          evtSingle,
  output logic          evtDouble,
  output logic          evtAddr
);
  localparam int K     = DW + 1;
  localparam int R     = checkBits(K);
  localparam int N     = K + R;
  localparam int CW    = N + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [R-1:0] NMAX = R'(N);

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] wordQ;
  logic [AW-1:0] addrQ;
  logic [R-1:0]  syn;
  logic          overall;
  logic [CW-1:0] fixedWord;
  logic [K-1:0]  field;
  logic [K-1:0]  encField;

  function automatic logic [CW-1:0] encodeWord(logic [K-1:0] f);
    logic [CW-1:0] w;
    logic [R-1:0]  s;
    int j;
    w = '0;
    s = '0;
    j = 0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p] = f[j];
        j++;
      end
    end
    for (int p = 1; p <= N; p++) if (w[p]) s ^= R'(p);
    for (int i = 0; i < R; i++) w[1 << i] = s[i];
    w[0] = ^w;
    return w;
  endfunction

  function automatic logic [K-1:0] extractField(logic [CW-1:0] w);
    logic [K-1:0] f;
    int j;
    f = '0;
    j = 0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        f[j] = w[p];
        j++;
      end
    end
    return f;
  endfunction

  // Decode of the registered word.
  always_comb begin
    syn = '0;
    for (int p = 1; p <= N; p++) if (wordQ[p]) syn ^= R'(p);
    overall   = ^wordQ;
    evtSingle = overall && (syn <= NMAX);
    evtDouble = (syn != '0 && !overall) || (overall && syn > NMAX);
    fixedWord = wordQ;
    if (evtSingle) fixedWord[syn] = ~fixedWord[syn];
    field   = extractField(fixedWord);
    rdData  = field[DW-1:0];
    evtAddr = !evtDouble && (field[K-1] != ^addrQ);
  end

  assign encField = {^memAddr, strobe.useFixed ? field[DW-1:0] : wrData};

  always_ff @(posedge clk) begin
    if (strobe.memWrite) mem[memAddr] <= encodeWord(encField);
    if (strobe.memRead) begin
      wordQ <= mem[memAddr];
      addrQ <= memAddr;
    end
  end

endmodule

// File: rtl/guarded_ram_ctrl.sv
module guarded_ram_ctrl
  import guarded_ram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          scrubEn,
  input  logic          csrWrite,
  input  logic          csrAddr,
  input  logic [1:0]    csrWdata,
  input  logic          evtSingle,
  input  logic          evtDouble,
  input  logic          evtAddr,
  output memStrobe_t    strobe,
  output logic [AW-1:0] memAddr,
  output logic          rdValid,
  output logic [1:0]    csrRdata,
  output logic          faultIrq,
  output logic          errIrq
);
  logic pendFunc, pendScrub;
  logic [AW-1:0] scrubPtr;
  logic secFlag, dedFlag, escalate;
  logic evalValid, secEvt, dedEvt, fixable, wbNow, scrubRead, ptrStep, clrHit;

  always_comb begin
    evalValid = pendFunc | pendScrub;
    secEvt    = evalValid & evtSingle;
    dedEvt    = evalValid & (evtDouble | evtAddr);
    fixable   = pendScrub & evtSingle & ~evtDouble & ~evtAddr;
    wbNow     = fixable & ~req;
    scrubRead = scrubEn & ~req & ~pendScrub;
    ptrStep   = pendScrub & (~fixable | wbNow);
    clrHit    = csrWrite & csrAddr;
    strobe.memWrite = (req & we) | wbNow;
    strobe.memRead  = (req & ~we) | scrubRead;
    strobe.useFixed = wbNow;
    memAddr   = req ? addr : scrubPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFunc  <= 1'b0;
      pendScrub <= 1'b0;
      scrubPtr  <= '0;
      secFlag   <= 1'b0;
      dedFlag   <= 1'b0;
      escalate  <= 1'b0;
    end else begin
      pendFunc  <= req & ~we;
      pendScrub <= scrubRead;
      if (ptrStep) scrubPtr <= scrubPtr + AW'(1);
      secFlag <= secEvt | (secFlag & ~(clrHit & csrWdata[0]));
      dedFlag <= dedEvt | (dedFlag & ~(clrHit & csrWdata[1]));
      if (csrWrite && !csrAddr) escalate <= csrWdata[0];
    end
  end

  assign rdValid  = pendFunc;
  assign csrRdata = csrAddr ? {dedFlag, secFlag} : {1'b0, escalate};
  assign faultIrq = secFlag & ~escalate;
  assign errIrq   = dedFlag | (secFlag & escalate);

  // R3
  dbl_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evalValid && evtDouble |=> dedFlag);
  // R4
  addr_fatal_chk: assert property (@(posedge clk) disable iff (!rstN)
    evalValid && evtAddr |=> errIrq);
  // R6
  sec_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    secFlag && !(csrWrite && csrAddr && csrWdata[0]) |=> secFlag);
  // R7
  ded_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrWrite && csrAddr && csrWdata[1] && !dedEvt |=> !dedFlag);
  // R8
  sec_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    evalValid && evtSingle && !escalate && !(csrWrite && !csrAddr) |=> faultIrq);

endmodule

// File: rtl/guarded_ram.sv
module guarded_ram
  import guarded_ram_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdValid,
  input  logic          scrubEn,
  input  logic          csrWrite,
  input  logic          csrAddr,
  input  logic [1:0]    csrWdata,
  output logic [1:0]    csrRdata,
  output logic          faultIrq,
  output logic          errIrq
);
  memStrobe_t    strobe;
  logic [AW-1:0] memAddr;
  logic          evtSingle, evtDouble, evtAddr;

  guarded_ram_ctrl #(.AW(AW)) ctrl (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr),
    .scrubEn(scrubEn), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .evtSingle(evtSingle), .evtDouble(evtDouble),
    .evtAddr(evtAddr), .strobe(strobe), .memAddr(memAddr),
    .rdValid(rdValid), .csrRdata(csrRdata), .faultIrq(faultIrq),
    .errIrq(errIrq)
  );

  guarded_ram_dp #(.DW(DW), .AW(AW)) dp (
    .clk(clk), .strobe(strobe), .memAddr(memAddr), .wrData(wdata),
    .rdData(rdata), .evtSingle(evtSingle), .evtDouble(evtDouble),
    .evtAddr(evtAddr)
  );

  // R9
  read_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    req && !we |=> rdValid);

endmodule

// File: tb/guarded_ram_test.sv
module guarded_ram_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rdValid, faultIrq, errIrq;
  logic scrubEn = 1'b0, csrWrite = 1'b0, csrAddr = 1'b0;
  logic [1:0] csrWdata = '0;
  logic [1:0] csrRdata;

  int checks = 0, errors = 0;
  bit done = 0;

  guarded_ram uut (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdValid(rdValid), .scrubEn(scrubEn), .csrWrite(csrWrite),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .faultIrq(faultIrq), .errIrq(errIrq)
  );

  always #5 clk = ~clk;

  // Reference model: kind 0 clean, 1 one flip, 2 two flips, 3 wrong row.
  logic [15:0] expMem [16];
  int kind [16];
  bit mSec, mDed, mEsc, pV, cmpIrq = 1;
  int pAddr;
  logic [15:0] pData;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit s, d;
    if (!rstN) begin
      mSec = 0; mDed = 0; mEsc = 0; pV = 0;
    end else begin
      s = 0; d = 0;
      if (pV) begin
        if (kind[pAddr] == 1) s = 1;
        if (kind[pAddr] >= 2) d = 1;
      end
      if (csrWrite && csrAddr) begin
        if (csrWdata[0]) mSec = 0;
        if (csrWdata[1]) mDed = 0;
      end
      if (s) mSec = 1;
      if (d) mDed = 1;
      if (csrWrite && !csrAddr) mEsc = csrWdata[0];
      pV = req && !we;
      pAddr = int'(addr);
      pData = expMem[addr];
      if (req && we) begin
        expMem[addr] = wdata;
        kind[addr] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(rdValid == pV, "R2 rdValid", rdValid, pV);
      if (pV && kind[pAddr] <= 1) chk(rdata == pData, "R2 rdata", rdata, pData);
      if (cmpIrq) begin
        chk(faultIrq == (mSec && !mEsc), "R8 faultIrq", faultIrq, mSec && !mEsc);
        chk(errIrq == (mDed || (mSec && mEsc)), "R8 errIrq", errIrq, mDed || (mSec && mEsc));
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic doWrite(int a, logic [15:0] d);
    req = 1; we = 1; addr = 4'(a); wdata = d;
    cyc();
    req = 0; we = 0;
  endtask

  task automatic doRead(int a);
    req = 1; we = 0; addr = 4'(a);
    cyc();
    req = 0;
  endtask

  task automatic csrWr(bit a, logic [1:0] d);
    csrWrite = 1; csrAddr = a; csrWdata = d;
    cyc();
    csrWrite = 0;
  endtask

  task automatic csrChk(bit a, logic [1:0] exp, string tag);
    csrAddr = a;
    @(negedge clk);
    chk(csrRdata == exp, tag, csrRdata, exp);
    cyc();
  endtask

  function automatic logic [15:0] pat(int a);
    return 16'(a * 16'h1357) ^ 16'h5A3C;
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) kind[i] = 0;
    cyc(3);
    rstN = 1;
    cyc();
    // R11 reset state
    @(negedge clk);
    chk(!faultIrq && !errIrq && !rdValid, "R11 outputs", {faultIrq, errIrq, rdValid}, 0);
    cyc();
    csrChk(1, 2'b00, "R11 status");
    csrChk(0, 2'b00, "R11 escalation");

    // R1 fill and read back
    for (int a = 0; a < 16; a++) doWrite(a, pat(a));
    for (int a = 0; a < 16; a++) doRead(a);
    cyc(2);
    csrChk(1, 2'b00, "R1 clean readback");

    // R6 single flip corrected and flagged
    uut.dp.mem[2][7] = ~uut.dp.mem[2][7];
    kind[2] = 1;
    doRead(2);
    cyc(2);
    csrChk(1, 2'b01, "R6 single flag");
    cyc(5);
    csrChk(1, 2'b01, "R6 sticky");
    csrWr(1, 2'b01);
    csrChk(1, 2'b00, "R7 clear corrected");

    // R3 double flip
    uut.dp.mem[4][3] = ~uut.dp.mem[4][3];
    uut.dp.mem[4][10] = ~uut.dp.mem[4][10];
    kind[4] = 2;
    doRead(4);
    cyc(2);
    csrChk(1, 2'b10, "R3 double flag");
    cyc(4);
    csrChk(1, 2'b10, "R6 sticky double");
    csrWr(1, 2'b10);
    csrChk(1, 2'b00, "R7 clear uncorrectable");

    // R8 escalation with correction still applied (R2)
    csrWr(0, 2'b01);
    csrChk(0, 2'b01, "R8 escalation readback");
    doRead(2);
    cyc(2);
    @(negedge clk);
    chk(errIrq && !faultIrq, "R8 escalated route", {faultIrq, errIrq}, 2'b01);
    cyc();
    csrChk(1, 2'b01, "R8 escalated flag");
    csrWr(1, 2'b01);
    csrWr(0, 2'b00);

    // R5 flipped address-parity bit
    uut.dp.mem[6][22] = ~uut.dp.mem[6][22];
    kind[6] = 1;
    doRead(6);
    cyc(2);
    csrChk(1, 2'b01, "R5 parity bit corrected");
    csrWr(1, 2'b01);

    // R4 wrong row returned (row 3 copied into row 1, parities differ)
    uut.dp.mem[1] = uut.dp.mem[3];
    kind[1] = 3;
    doRead(1);
    cyc(2);
    csrChk(1, 2'b10, "R4 address mismatch");
    @(negedge clk);
    chk(errIrq, "R4 fatal output", errIrq, 1);
    cyc();
    // R7 clear in the same cycle as a new event: event wins
    csrWr(1, 2'b10);
    req = 1; we = 0; addr = 4'd1;
    cyc();
    req = 0;
    csrWrite = 1; csrAddr = 1; csrWdata = 2'b10;
    cyc();
    csrWrite = 0;
    csrChk(1, 2'b10, "R7 event beats clear");
    csrWr(1, 2'b10);

    for (int a = 0; a < 8; a++) doWrite(a, pat(a + 20));

    // R9 scrubber starved by back-to-back requests
    uut.dp.mem[9][0] = ~uut.dp.mem[9][0];
    uut.dp.mem[12][15] = ~uut.dp.mem[12][15];
    kind[9] = 1;
    kind[12] = 1;
    cmpIrq = 0;
    scrubEn = 1;
    req = 1; we = 0;
    for (int i = 0; i < 40; i++) begin
      addr = 4'(i % 8);
      cyc();
    end
    req = 0;
    scrubEn = 0;
    cyc(3);
    csrChk(1, 2'b00, "R9 no scrub under load");

    // R10 idle scrub repairs both words
    scrubEn = 1;
    cyc(80);
    scrubEn = 0;
    cyc(3);
    csrChk(1, 2'b01, "R10 scrub detection");
    csrWr(1, 2'b01);
    kind[9] = 0;
    kind[12] = 0;
    cyc();
    cmpIrq = 1;
    doRead(9);
    doRead(12);
    cyc(2);
    csrChk(1, 2'b00, "R10 words repaired");

    cyc(2);
    done = 1;
    summary();
    $finish;
  end
endmodule